// File: doc/BRIEF.md
# Reset and NMI request deglitcher

This block cleans two active-low request lines before they reach the processor core and the peripherals: an external reset pin and a non-maskable interrupt request. The interrupt request may come from an internal watchdog rather than from a pin. Each line has its own channel, run from the system clock. A channel first passes the raw line through a synchronizer. It then applies a run-length filter, so the cleaned output takes a new level only after the synchronized line has held that level for `FILT_LEN` consecutive clocks. Anything shorter is treated as a glitch and dropped.

Each channel has its own enable bit. With the bit set, the channel drives its output from the filter. With the bit clear, the output follows the raw line through logic alone, so a reset still gets through when the system clock is stopped. In normal use the reset channel is enabled. While the power-on reset `por_n` is low, both outputs are held high (inactive).

Each filter is a four-state machine:
- `ST_STEADY_HI` moves to `ST_CONFIRM_LO` on a low sample. This is the *start-fall* transition.
- `ST_CONFIRM_LO` returns to `ST_STEADY_HI` on a high sample. This is the *abort-fall* transition.
- `ST_CONFIRM_LO` moves to `ST_STEADY_LO` once `FILT_LEN` low samples have been counted. This is the *commit-fall* transition.
- The rising side mirrors the falling side. `ST_STEADY_LO` moves to `ST_CONFIRM_HI` (*start-rise*). `ST_CONFIRM_HI` returns to `ST_STEADY_LO` on a low sample (*abort-rise*). `ST_CONFIRM_HI` moves to `ST_STEADY_HI` after `FILT_LEN` high samples (*commit-rise*).

The output is low in `ST_STEADY_LO` and in `ST_CONFIRM_HI`, and high in the other two states.

Top module: `req_deglitch_pair`

## Requirements
- R1: While `por_n` is low, `rst_clean_n` and `nmi_clean_n` are both 1, whatever the raw inputs and enable bits are. After `por_n` rises, each filter starts in the high (inactive) state.
- R2: With a channel's enable bit at 1, a new level on its raw input that is held steadily appears at the output after a fixed latency. The output changes just after the (`SYNC_STAGES` + `FILT_LEN`)-th rising clock edge at which the raw input is sampled at the new level. With the defaults this is the 6th edge.
- R3: With a channel's enable bit at 1, a raw pulse sampled at fewer than `FILT_LEN` consecutive edges causes no change at that channel's output.
- R4: With `rst_flt_en` = 0 and `por_n` = 1, `rst_clean_n` equals `rst_pin_n` with no clock edge in between.
- R5: With `nmi_flt_en` = 0 and `por_n` = 1, `nmi_clean_n` equals `nmi_req_n` with no clock edge in between.
- R6: The two channels are independent. Activity on one raw input or enable bit has no effect on the other channel's output.
- R7: Falling and rising transitions are filtered the same way. A return to high also needs `FILT_LEN` consecutive high samples, and a shorter high glitch while the output is low is dropped.
- R8: A channel's filter keeps tracking its input while the channel is bypassed. When the enable bit is set, the output immediately shows the level that the filter has built up from the recent input history.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_sys | input | 1 | System clock for the synchronizers and filters |
| por_n | input | 1 | Power-on reset, active low, asynchronous |
| rst_pin_n | input | 1 | Raw external reset request, active low |
| nmi_req_n | input | 1 | Raw NMI request (pin or watchdog), active low |
| rst_flt_en | input | 1 | 1: filter the reset channel, 0: bypass it |
| nmi_flt_en | input | 1 | 1: filter the NMI channel, 0: bypass it |
| rst_clean_n | output | 1 | Cleaned reset request, active low |
| nmi_clean_n | output | 1 | Cleaned NMI request, active low |

## Verification
The bench builds the block with the defaults `FILT_LEN` = 4 and `SYNC_STAGES` = 2. A filter length this short lets random runs of 1 to 10 clocks cross the commit threshold often. The bench therefore sees many runs of exactly `FILT_LEN` - 1 samples and exactly `FILT_LEN` samples, and many aborted confirmations in both directions. Random toggling of the enable bits while the filters keep running brings the bypass-to-filter handover of R8 within reach.

// File: rtl/req_deglitch_pkg.sv
package req_deglitch_pkg;

    typedef enum logic [1:0] {
        ST_STEADY_HI  = 2'b00,
        ST_CONFIRM_LO = 2'b01,
        ST_STEADY_LO  = 2'b10,
        ST_CONFIRM_HI = 2'b11
    } flt_state_e;

    localparam int NUM_CH = 2;
    localparam int CH_RST = 0;
    localparam int CH_NMI = 1;

endpackage

// File: rtl/req_sync_chain.sv
module req_sync_chain #(
    parameter int   STAGES    = 2,
    parameter logic RESET_VAL = 1'b1
) (
    input  logic clk,
    input  logic rst_n,
    input  logic d_async,
    output logic q_sync
);

    logic [STAGES-1:0] shift_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            shift_q <= {STAGES{RESET_VAL}};
        end else begin
            shift_q <= {shift_q[STAGES-2:0], d_async};
        end
    end

    assign q_sync = shift_q[STAGES-1];

endmodule

// File: rtl/req_glitch_fsm.sv
module req_glitch_fsm
    import req_deglitch_pkg::*;
#(
    parameter int FILT_LEN = 4
) (
    input  logic clk,
    input  logic rst_n,
    input  logic level_in,
    output logic level_out
);

    localparam int CW = (FILT_LEN < 2) ? 1 : $clog2(FILT_LEN + 1);
    localparam logic [CW-1:0] LAST_CNT = CW'(FILT_LEN - 1);

    flt_state_e    state_q, state_d;
    logic [CW-1:0] cnt_q, cnt_d;

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_STEADY_HI;
            cnt_q   <= '0;
        end else begin
            state_q <= state_d;
            cnt_q   <= cnt_d;
        end
    end

    // transitions
    always_comb begin
        state_d = state_q;
        cnt_d   = cnt_q;
        unique case (state_q)
            ST_STEADY_HI: begin
                if (!level_in) begin
                    if (LAST_CNT == '0) begin
                        state_d = ST_STEADY_LO;
                    end else begin
                        state_d = ST_CONFIRM_LO;
                        cnt_d   = CW'(1);
                    end
                end
            end
            ST_CONFIRM_LO: begin
                if (level_in) begin
                    state_d = ST_STEADY_HI;
                    cnt_d   = '0;
                end else if (cnt_q == LAST_CNT) begin
                    state_d = ST_STEADY_LO;
                    cnt_d   = '0;
                end else begin
                    cnt_d = cnt_q + CW'(1);
                end
            end
            ST_STEADY_LO: begin
                if (level_in) begin
                    if (LAST_CNT == '0) begin
                        state_d = ST_STEADY_HI;
                    end else begin
                        state_d = ST_CONFIRM_HI;
                        cnt_d   = CW'(1);
                    end
                end
            end
            ST_CONFIRM_HI: begin
                if (!level_in) begin
                    state_d = ST_STEADY_LO;
                    cnt_d   = '0;
                end else if (cnt_q == LAST_CNT) begin
                    state_d = ST_STEADY_HI;
                    cnt_d   = '0;
                end else begin
                    cnt_d = cnt_q + CW'(1);
                end
            end
            default: begin
                state_d = ST_STEADY_HI;
                cnt_d   = '0;
            end
        endcase
    end

    // outputs
    always_comb begin
        unique case (state_q)
            ST_STEADY_LO, ST_CONFIRM_HI: level_out = 1'b0;
            default:                     level_out = 1'b1;
        endcase
    end

    // R3
    cnt_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cnt_q <= LAST_CNT);

    // R2
    steady_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (level_in == level_out) |=> $stable(level_out));

    // R7
    flip_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (level_out != $past(level_out)) |-> ($past(level_in) == level_out));

    // R7
    abort_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_CONFIRM_HI && !level_in) |=> (state_q == ST_STEADY_LO));

endmodule

// File: rtl/req_filter_channel.sv
module req_filter_channel #(
    parameter int FILT_LEN    = 4,
    parameter int SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic por_n,
    input  logic raw_n,
    input  logic flt_en,
    output logic clean_n
);

    logic synced_n;
    logic filtered_n;

    req_sync_chain #(
        .STAGES    (SYNC_STAGES),
        .RESET_VAL (1'b1)
    ) u_sync (
        .clk     (clk),
        .rst_n   (por_n),
        .d_async (raw_n),
        .q_sync  (synced_n)
    );

    req_glitch_fsm #(
        .FILT_LEN (FILT_LEN)
    ) u_fsm (
        .clk       (clk),
        .rst_n     (por_n),
        .level_in  (synced_n),
        .level_out (filtered_n)
    );

    always_comb begin
        if (!por_n) begin
            clean_n = 1'b1;
        end else if (flt_en) begin
            clean_n = filtered_n;
        end else begin
            clean_n = raw_n;
        end
    end

endmodule

// File: rtl/req_deglitch_pair.sv
module req_deglitch_pair
    import req_deglitch_pkg::*;
#(
    parameter int FILT_LEN    = 4,
    parameter int SYNC_STAGES = 2
) (
    input  logic clk_sys,
    input  logic por_n,
    input  logic rst_pin_n,
    input  logic nmi_req_n,
    input  logic rst_flt_en,
    input  logic nmi_flt_en,
    output logic rst_clean_n,
    output logic nmi_clean_n
);

    logic [NUM_CH-1:0] raw_v;
    logic [NUM_CH-1:0] en_v;
    logic [NUM_CH-1:0] clean_v;

    assign raw_v[CH_RST] = rst_pin_n;
    assign raw_v[CH_NMI] = nmi_req_n;
    assign en_v[CH_RST]  = rst_flt_en;
    assign en_v[CH_NMI]  = nmi_flt_en;

    for (genvar ch = 0; ch < NUM_CH; ch++) begin : g_ch
        req_filter_channel #(
            .FILT_LEN    (FILT_LEN),
            .SYNC_STAGES (SYNC_STAGES)
        ) u_chan (
            .clk     (clk_sys),
            .por_n   (por_n),
            .raw_n   (raw_v[ch]),
            .flt_en  (en_v[ch]),
            .clean_n (clean_v[ch])
        );
    end

    assign rst_clean_n = clean_v[CH_RST];
    assign nmi_clean_n = clean_v[CH_NMI];

    // R1
    always_comb begin
        if (por_n === 1'b0) begin
            por_idle_chk: assert (rst_clean_n === 1'b1 && nmi_clean_n === 1'b1);
        end
    end

endmodule

// File: tb/req_deglitch_pair_tb.sv
module req_deglitch_pair_tb;

    localparam int FL = 4;
    localparam int SS = 2;
    localparam int HL = SS + FL;
    localparam time TCLK = 20ns;

    logic clk_sys = 1'b0;
    logic por_n, rst_pin_n, nmi_req_n, rst_flt_en, nmi_flt_en;
    logic rst_clean_n, nmi_clean_n;

    int checks = 0;
    int failures = 0;
    bit done = 0;

    logic hist [2][HL];
    logic expf [2];
    bit   rst_went_low;

    always #(TCLK/2) clk_sys = ~clk_sys;

    req_deglitch_pair #(.FILT_LEN(FL), .SYNC_STAGES(SS)) u_dut (
        .clk_sys     (clk_sys),
        .por_n       (por_n),
        .rst_pin_n   (rst_pin_n),
        .nmi_req_n   (nmi_req_n),
        .rst_flt_en  (rst_flt_en),
        .nmi_flt_en  (nmi_flt_en),
        .rst_clean_n (rst_clean_n),
        .nmi_clean_n (nmi_clean_n)
    );

    function automatic logic raw_of(int ch);
        return (ch == 0) ? rst_pin_n : nmi_req_n;
    endfunction

    function automatic logic en_of(int ch);
        return (ch == 0) ? rst_flt_en : nmi_flt_en;
    endfunction

    function automatic logic out_of(int ch);
        return (ch == 0) ? rst_clean_n : nmi_clean_n;
    endfunction

    function automatic logic model_out(int ch);
        if (!por_n) return 1'b1;
        if (en_of(ch)) return expf[ch];
        return raw_of(ch);
    endfunction

    task automatic check(string tag, logic act, logic exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%b expected=%b t=%0t", tag, act, exp, $time);
        end
    endtask

    task automatic check_model(string tag0, string tag1);
        check(tag0, rst_clean_n, model_out(0));
        check(tag1, nmi_clean_n, model_out(1));
    endtask

    function automatic string tag_for(int ch);
        if (en_of(ch)) return "R2";
        return (ch == 0) ? "R4" : "R5";
    endfunction

    task automatic model_reset();
        for (int ch = 0; ch < 2; ch++) begin
            for (int i = 0; i < HL; i++) hist[ch][i] = 1'b1;
            expf[ch] = 1'b1;
        end
    endtask

    // one rising edge, model update, compare at the following falling edge
    task automatic step();
        bit all_eq;
        @(posedge clk_sys);
        for (int ch = 0; ch < 2; ch++) begin
            for (int i = HL - 1; i > 0; i--) hist[ch][i] = hist[ch][i-1];
            hist[ch][0] = raw_of(ch);
            all_eq = 1'b1;
            for (int i = SS; i < HL; i++) if (hist[ch][i] != hist[ch][SS]) all_eq = 1'b0;
            if (all_eq && hist[ch][SS] != expf[ch]) expf[ch] = hist[ch][SS];
        end
        @(negedge clk_sys);
        if (rst_clean_n == 1'b0) rst_went_low = 1'b1;
        check_model(tag_for(0), tag_for(1));
    endtask

    task automatic latency(int ch, logic lvl, string tag);
        int n = 0;
        if (ch == 0) rst_pin_n = lvl; else nmi_req_n = lvl;
        while (out_of(ch) != lvl && n < 20) begin
            step();
            n++;
        end
        check(tag, (n == SS + FL), 1'b1);
    endtask

    initial begin
        #(TCLK * 200000);
        if (!done) begin
            failures++;
            $display("FAIL watchdog expired");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd20240611));
        por_n = 1'b0; rst_pin_n = 1'b0; nmi_req_n = 1'b0;
        rst_flt_en = 1'b0; nmi_flt_en = 1'b0;
        model_reset();
        #3;
        // R1: bypassed and raw low, still inactive under power-on reset
        check("R1", rst_clean_n, 1'b1);
        check("R1", nmi_clean_n, 1'b1);
        rst_flt_en = 1'b1; nmi_flt_en = 1'b1;
        repeat (3) @(negedge clk_sys);
        check("R1", rst_clean_n, 1'b1);
        check("R1", nmi_clean_n, 1'b1);
        rst_pin_n = 1'b1; nmi_req_n = 1'b1;
        @(negedge clk_sys);
        por_n = 1'b1;
        #1;
        check("R1", rst_clean_n, 1'b1);
        check("R1", nmi_clean_n, 1'b1);
        repeat (4) step();

        // R2 falling latency on reset, R7 rising latency
        latency(0, 1'b0, "R2");
        repeat (3) step();
        latency(0, 1'b1, "R7");
        repeat (3) step();

        // R3: short low pulse of FL-1 samples
        rst_went_low = 1'b0;
        rst_pin_n = 1'b0;
        repeat (FL - 1) step();
        rst_pin_n = 1'b1;
        repeat (8) step();
        check("R3", rst_went_low, 1'b0);

        // R7: short high glitch while output low is dropped
        latency(1, 1'b0, "R2");
        nmi_req_n = 1'b1;
        repeat (FL - 1) step();
        nmi_req_n = 1'b0;
        repeat (8) step();
        check("R7", nmi_clean_n, 1'b0);

        // R6: nmi activity leaves reset untouched
        rst_went_low = 1'b0;
        for (int k = 0; k < 40; k++) begin
            nmi_req_n = $urandom_range(0, 1);
            nmi_flt_en = $urandom_range(0, 1);
            step();
        end
        check("R6", rst_went_low, 1'b0);
        nmi_flt_en = 1'b1; nmi_req_n = 1'b1;
        repeat (8) step();

        // R4 / R5: combinational bypass
        rst_flt_en = 1'b0; nmi_flt_en = 1'b0;
        rst_pin_n = 1'b0; #1;
        check("R4", rst_clean_n, 1'b0);
        nmi_req_n = 1'b0; #1;
        check("R5", nmi_clean_n, 1'b0);
        check("R6", rst_clean_n, 1'b0);
        rst_pin_n = 1'b1; #1;
        check("R4", rst_clean_n, 1'b1);
        check("R6", nmi_clean_n, 1'b0);
        repeat (8) step();

        // R8: filter kept tracking nmi low while bypassed
        nmi_req_n = 1'b1; #1;
        check("R5", nmi_clean_n, 1'b1);
        nmi_flt_en = 1'b1; #1;
        check("R8", nmi_clean_n, 1'b0);
        repeat (10) step();
        check("R8", nmi_clean_n, 1'b1);
        rst_flt_en = 1'b1;

        // random runs against the bench model
        for (int seg = 0; seg < 600; seg++) begin
            int len = $urandom_range(1, 2 * FL + 2);
            int ch  = $urandom_range(0, 1);
            if (ch == 0) rst_pin_n = ~rst_pin_n; else nmi_req_n = ~nmi_req_n;
            if ($urandom_range(0, 15) == 0) begin
                rst_flt_en = $urandom_range(0, 1);
                nmi_flt_en = $urandom_range(0, 1);
                #1;
                check_model((rst_flt_en ? "R8" : "R4"), (nmi_flt_en ? "R8" : "R5"));
            end
            repeat (len) step();
        end

        done = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule